// File: doc/BRIEF.md
# Limp-Mode Clock Source Switch Controller

This block decides whether the chip runs from its main clock (the PLL or oscillator path) or from a backup ring-oscillator clock. It reacts to a loss-of-clock detect input, a PLL valid input and the chip hard-reset input. It also reacts to two software control bits: a limp enable and a forced-backup request. Each change of mode outside hard reset asks for a chip hard reset. The select itself goes through a break-before-make handshake: the gate of the old source is closed before the select moves, and the gate of the new source opens only after the select has settled.

Software reaches the controller through a one-word write/read port. The loss status comes in two forms. The live bit follows the detector. The sticky bit holds a detected loss until software writes a one to it. During hard reset the selection follows the health of the PLL. Once reset is released, the selection is frozen against further PLL changes. The analog PLL, the ring oscillator and the loss detector are outside the block and appear only as inputs.

Top module: `clksw_limp_ctrl`

## Requirements
- R1: After synchronous reset (`rst_n` low), `rd_data` is all zero, `clk_sel` is 0 (main), `en_main` is 1, `en_bkup` is 0 and `hreset_req` is 0.
- R2: `loss_live` (read bit 3) equals `loss_det` delayed by one clock. `loss_sticky` (read bit 2) is set by `loss_det`, stays set until a write with `wr_data[2]`=1, and a new loss wins over that clear.
- R3: With limp enable (bit 0) set and `loss_live` high, the block moves to backup (read bit 4 = 1, `clk_sel` = 1) and starts a hard-reset request pulse.
- R4: A write with `wr_data[1]`=1 and `wr_data[0]`=1 sets force-backup (read bit 1), which enters backup and requests a hard reset. A write with `wr_data[0]`=0 leaves force-backup at 0 with no switch and no pulse, and a loss with enable clear causes no switch.
- R5: In backup with enable set, clearing both force-backup and the sticky bit (with no live loss) returns to main and requests a hard reset.
- R6: A write that clears enable while in backup returns the block to main, clears force-backup and requests a hard reset.
- R7: While `hard_rst` is high, the selection becomes backup and the sticky bit is set whenever `pll_valid` is low, and no pulse is requested. After release, `pll_valid` changes do not move the selection, and a backup selection made this way holds until software clears the sticky bit. Leaving it then requests a hard reset.
- R8: `en_main` and `en_bkup` are never high together. `clk_sel` changes only while both are low. Once the switch has settled, the gate matching `clk_sel` is high.
- R9: Each mode transition outside hard reset produces exactly one `hreset_req` pulse of `PULSE_LEN` (16) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hard_rst | input | 1 | Chip hard reset currently asserted |
| loss_det | input | 1 | Loss-of-clock detector output |
| pll_valid | input | 1 | PLL output locked and valid |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 3 | [0] limp enable, [1] force backup, [2] write-one-to-clear sticky |
| rd_data | output | 5 | [0] enable, [1] force, [2] sticky, [3] live, [4] backup selected |
| clk_sel | output | 1 | Mux select: 0 main, 1 backup |
| en_main | output | 1 | Main clock gate enable |
| en_bkup | output | 1 | Backup clock gate enable |
| hreset_req | output | 1 | Hard-reset request pulse |
| loss_live | output | 1 | Live loss-of-clock status |
| loss_sticky | output | 1 | Sticky loss-of-clock status |

## Verification
The bench first shows that a loss, or a force write, has no effect while enable is clear. A design that did not gate on the enable bit would fail over and pulse reset at that point. It then covers the three ways out of backup: clearing both bits, clearing enable, and clearing the sticky bit after a reset-time failover. A design missing any of these would stay on the backup clock. Hard resets are applied with the PLL invalid, valid, and failing mid-reset, and the PLL is toggled after release. A design that kept following the PLL after release, or pulsed during reset, would show the wrong selection or an extra pulse. Every pulse is measured, and a design with an off-by-one counter or a lost restart would give the wrong length or count.

// File: rtl/clksw_pkg.sv
// Shared definitions for the limp-mode clock switch controller.
// Assumes a single controller clock domain for all state.
package clksw_pkg;
    localparam int CTRL_W  = 3;   // write data width
    localparam int STAT_W  = 5;   // read data width
    localparam int B_EN    = 0;   // limp enable
    localparam int B_FORCE = 1;   // force backup
    localparam int B_STICK = 2;   // sticky loss (W1C)
    localparam int B_LIVE  = 3;   // live loss (read only)
    localparam int B_LIMP  = 4;   // backup selected (read only)

    typedef enum logic [1:0] {
        MUX_IDLE  = 2'd0,
        MUX_DROP  = 2'd1,
        MUX_RAISE = 2'd2
    } mux_state_e;
endpackage

// File: rtl/clksw_ctrl_regs.sv
// Control and status register for the controller.
// Holds limp enable, force backup and the sticky loss bit; registers the live loss.
// Assumes loss_det is already synchronous to clk. Force can only be set with enable.
module clksw_ctrl_regs
    import clksw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              loss_det,
    input  logic              set_sticky,
    output logic              enable,
    output logic              force_bk,
    output logic              sticky,
    output logic              live
);
    // Software-written enable and force bits; a force write without enable is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable   <= 1'b0;
            force_bk <= 1'b0;
        end else if (wr_en) begin
            enable   <= wr_data[B_EN];
            force_bk <= wr_data[B_FORCE] & wr_data[B_EN];
        end
    end

    // Live status mirrors the detector with one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= loss_det;
    end

    // Sticky bit: any new loss has priority over a write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                          sticky <= 1'b0;
        else if (loss_det || set_sticky)     sticky <= 1'b1;
        else if (wr_en && wr_data[B_STICK])  sticky <= 1'b0;
    end
endmodule

// File: rtl/clksw_mode_fsm.sv
// Mode decision: normal (main clock) or limp (backup clock).
// During hard reset the mode follows PLL health and no reset request is made;
// outside reset, entries and exits follow the software bits and loss status,
// and each one raises a one-cycle start strobe for the reset pulse generator.
module clksw_mode_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic hard_rst,
    input  logic pll_valid,
    input  logic enable,
    input  logic force_bk,
    input  logic sticky,
    input  logic live,
    output logic in_limp,
    output logic start_pulse,
    output logic set_sticky
);
    logic en_q;
    logic hrst_q;
    logic pll_fail;
    logic enter;
    logic leave;

    assign pll_fail    = ~pll_valid | live;
    assign enter       = ~in_limp & enable & (live | force_bk);
    assign leave       = in_limp & ((en_q & ~enable) | (~force_bk & ~sticky & ~live));
    assign start_pulse = ~hard_rst & (enter | leave);
    assign set_sticky  = hard_rst & ~pll_valid;

    // Edge history of the enable bit and the hard-reset input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            hrst_q <= 1'b0;
        end else begin
            en_q   <= enable;
            hrst_q <= hard_rst;
        end
    end

    // Mode register: reset-time sampling first, then software/loss transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_limp <= 1'b0;
        end else if (hard_rst) begin
            if (!hrst_q)       in_limp <= pll_fail;
            else if (pll_fail) in_limp <= 1'b1;
        end else if (enter) begin
            in_limp <= 1'b1;
        end else if (leave) begin
            in_limp <= 1'b0;
        end
    end
endmodule

// File: rtl/clksw_pulse_gen.sv
// Fixed-length hard-reset request pulse generator.
// A start strobe (re)loads the counter; the output is a registered level that
// stays high for exactly LEN cycles after the last start.
module clksw_pulse_gen #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LOAD = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    // Count down the remaining pulse cycles and drop the output at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (start) begin
            cnt   <= LOAD;
            pulse <= 1'b1;
        end else if (cnt != '0) begin
            cnt   <= cnt - 1'b1;
        end else begin
            pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/clksw_bbm_mux.sv
// Break-before-make select handshake for the clock mux.
// On a new target: close both gates, wait SYNC cycles for the old clock
// domain to acknowledge, move the select, wait SYNC cycles, open the new gate.
// Assumes the target may change at any time; a change mid-switch is taken
// up when the current switch completes.
module clksw_bbm_mux
    import clksw_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic target,
    output logic sel,
    output logic en_main,
    output logic en_bkup
);
    localparam int CW = (SYNC > 1) ? $clog2(SYNC) : 1;
    localparam logic [CW-1:0] LAST = CW'(SYNC - 1);

    mux_state_e    state;
    logic [CW-1:0] cnt;

    // Handshake sequencer driving the select and both gate enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= MUX_IDLE;
            cnt     <= '0;
            sel     <= 1'b0;
            en_main <= 1'b1;
            en_bkup <= 1'b0;
        end else begin
            case (state)
                MUX_IDLE: begin
                    if (target != sel) begin
                        en_main <= 1'b0;
                        en_bkup <= 1'b0;
                        cnt     <= '0;
                        state   <= MUX_DROP;
                    end
                end
                MUX_DROP: begin
                    if (cnt == LAST) begin
                        sel   <= target;
                        cnt   <= '0;
                        state <= MUX_RAISE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                MUX_RAISE: begin
                    if (cnt == LAST) begin
                        en_main <= ~sel;
                        en_bkup <= sel;
                        state   <= MUX_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= MUX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/clksw_limp_ctrl.sv
// Top of the limp-mode clock source switch controller.
// Ties the control register, mode decision, reset pulse generator and
// break-before-make mux handshake together. All inputs are assumed
// synchronous to clk; rst_n is a synchronous active-low reset.
module clksw_limp_ctrl
    import clksw_pkg::*;
#(
    parameter int PULSE_LEN   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hard_rst,
    input  logic              loss_det,
    input  logic              pll_valid,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [STAT_W-1:0] rd_data,
    output logic              clk_sel,
    output logic              en_main,
    output logic              en_bkup,
    output logic              hreset_req,
    output logic              loss_live,
    output logic              loss_sticky
);
    logic enable;
    logic force_bk;
    logic in_limp;
    logic start_pulse;
    logic set_sticky;

    clksw_ctrl_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .loss_det   (loss_det),
        .set_sticky (set_sticky),
        .enable     (enable),
        .force_bk   (force_bk),
        .sticky     (loss_sticky),
        .live       (loss_live)
    );

    clksw_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hard_rst    (hard_rst),
        .pll_valid   (pll_valid),
        .enable      (enable),
        .force_bk    (force_bk),
        .sticky      (loss_sticky),
        .live        (loss_live),
        .in_limp     (in_limp),
        .start_pulse (start_pulse),
        .set_sticky  (set_sticky)
    );

    clksw_pulse_gen #(.LEN(PULSE_LEN)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_pulse),
        .pulse (hreset_req)
    );

    clksw_bbm_mux #(.SYNC(SYNC_STAGES)) u_mux (
        .clk     (clk),
        .rst_n   (rst_n),
        .target  (in_limp),
        .sel     (clk_sel),
        .en_main (en_main),
        .en_bkup (en_bkup)
    );

    // Status word assembly for the read port.
    always_comb begin
        rd_data          = '0;
        rd_data[B_EN]    = enable;
        rd_data[B_FORCE] = force_bk;
        rd_data[B_STICK] = loss_sticky;
        rd_data[B_LIVE]  = loss_live;
        rd_data[B_LIMP]  = in_limp;
    end
endmodule

// File: rtl/clksw_limp_ctrl_chk.sv
// Property checker for clksw_limp_ctrl, attached by bind below.
// Observes ports only; counts reset pulse length with a local counter.
module clksw_limp_ctrl_chk
    import clksw_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hard_rst,
    input logic              loss_det,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wr_data,
    input logic [STAT_W-1:0] rd_data,
    input logic              clk_sel,
    input logic              en_main,
    input logic              en_bkup,
    input logic              hreset_req,
    input logic              loss_live,
    input logic              loss_sticky
);
    int unsigned hi_cnt;

    // Length of the current high phase of the reset request.
    always_ff @(posedge clk) begin
        if (!rst_n)          hi_cnt <= 0;
        else if (hreset_req) hi_cnt <= hi_cnt + 1;
        else                 hi_cnt <= 0;
    end

    p_live_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        loss_det |=> loss_live);
    p_live_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !loss_det |=> !loss_live);
    p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loss_sticky) |-> $past(wr_en && wr_data[B_STICK]));
    p_pulse_on_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_data[B_LIMP]) && !$past(hard_rst)) |-> hreset_req);
    p_force_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[B_EN]) |=> !rd_data[B_FORCE]);
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_main && en_bkup));
    p_sel_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_sel) |-> ($past(!en_main) && $past(!en_bkup)));
    p_pulse_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hreset_req) |-> (hi_cnt == PULSE_LEN));
endmodule

bind clksw_limp_ctrl clksw_limp_ctrl_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hard_rst    (hard_rst),
    .loss_det    (loss_det),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .clk_sel     (clk_sel),
    .en_main     (en_main),
    .en_bkup     (en_bkup),
    .hreset_req  (hreset_req),
    .loss_live   (loss_live),
    .loss_sticky (loss_sticky)
);

// File: tb/clksw_limp_ctrl_tb_top.sv
// Scoreboard bench: the driver queues expected settled states, a monitor
// pops each one after the switch and pulse have settled and compares.
module clksw_limp_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE_LEN  = 16;
    localparam int SETTLE     = 40;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hard_rst = 1'b0;
    logic       loss_det = 1'b0;
    logic       pll_valid = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_data = '0;
    logic [4:0] rd_data;
    logic       clk_sel, en_main, en_bkup, hreset_req, loss_live, loss_sticky;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    int hi_len = 0;
    int pending = 0;
    bit done = 1'b0;

    typedef struct {
        logic       sel;
        logic [4:0] rd;
        int         npulse;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    clksw_limp_ctrl #(.PULSE_LEN(PULSE_LEN), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .hard_rst(hard_rst), .loss_det(loss_det),
        .pll_valid(pll_valid), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .clk_sel(clk_sel), .en_main(en_main),
        .en_bkup(en_bkup), .hreset_req(hreset_req), .loss_live(loss_live),
        .loss_sticky(loss_sticky)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [2:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_state(input logic sel, input logic [4:0] rd, input int np, input string tag);
        exp_t e;
        e.sel = sel; e.rd = rd; e.npulse = np; e.tag = tag;
        sb_q.push_back(e);
        pending++;
        wait (pending == 0);
    endtask

    task automatic pulse_loss(input int n);
        @(negedge clk);
        loss_det = 1'b1;
        repeat (n) @(negedge clk);
        loss_det = 1'b0;
    endtask

    // Pulse counter and length check for every reset request (R9).
    always @(negedge clk) begin
        if (rst_n) begin
            if (hreset_req) begin
                if (hi_len == 0) pulses++;
                hi_len++;
            end else if (hi_len != 0) begin
                chk(hi_len == PULSE_LEN, "R9 pulse length", hi_len, PULSE_LEN);
                hi_len = 0;
            end
        end
    end

    // Monitor: settle, then compare the settled ports against the queued item.
    initial begin
        forever begin
            wait (sb_q.size() > 0);
            repeat (SETTLE) @(negedge clk);
            begin
                exp_t e;
                logic [1:0] gates;
                e = sb_q.pop_front();
                gates = {en_bkup, en_main};
                chk(clk_sel == e.sel, {e.tag, " clk_sel"}, clk_sel, e.sel);
                chk(gates == {e.sel, ~e.sel}, {"R8 gates after ", e.tag}, gates, {e.sel, ~e.sel});
                chk(rd_data == e.rd, {e.tag, " rd_data"}, rd_data, e.rd);
                chk(pulses == e.npulse, {e.tag, " pulse count"}, pulses, e.npulse);
            end
            pending--;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Driver: stimulus sequence over all requirements.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_data == 5'b0, "R1 rd_data", rd_data, 0);
        chk({clk_sel, en_main, en_bkup, hreset_req} == 4'b0100, "R1 outputs",
            {clk_sel, en_main, en_bkup, hreset_req}, 4'b0100);

        // R2 live follows detector by one clock
        @(negedge clk); loss_det = 1'b1;
        @(negedge clk);
        chk(loss_live == 1'b1, "R2 live set", loss_live, 1);
        loss_det = 1'b0;
        @(negedge clk);
        chk(loss_live == 1'b0, "R2 live clear", loss_live, 0);
        // R4 loss with enable clear: no switch, sticky held (R2)
        pulse_loss(3);
        expect_state(1'b0, 5'b00100, 0, "R4 loss blocked/R2 sticky");
        write_reg(3'b100);
        expect_state(1'b0, 5'b00000, 0, "R2 sticky W1C");
        // R4 force without enable ignored
        write_reg(3'b010);
        expect_state(1'b0, 5'b00000, 0, "R4 force ignored");
        write_reg(3'b001);
        expect_state(1'b0, 5'b00001, 0, "R4 enable only");
        // R3 loss with enable -> backup
        pulse_loss(3);
        expect_state(1'b1, 5'b10101, 1, "R3 failover");
        // R5 clear sticky (force already 0) -> main
        write_reg(3'b101);
        expect_state(1'b0, 5'b00001, 2, "R5 return");
        // R4 force with enable -> backup, R5 clear force -> main
        write_reg(3'b011);
        expect_state(1'b1, 5'b10011, 3, "R4 force entry");
        write_reg(3'b001);
        expect_state(1'b0, 5'b00001, 4, "R5 force cleared");
        // R6 clear enable in limp
        write_reg(3'b011);
        expect_state(1'b1, 5'b10011, 5, "R6 enter");
        write_reg(3'b000);
        expect_state(1'b0, 5'b00000, 6, "R6 enable cleared");
        // R7 hard reset with PLL invalid -> backup, no pulse
        @(negedge clk); pll_valid = 1'b0; hard_rst = 1'b1;
        repeat (10) @(negedge clk);
        hard_rst = 1'b0;
        @(negedge clk); pll_valid = 1'b1;
        repeat (5) @(negedge clk); pll_valid = 1'b0;
        repeat (5) @(negedge clk); pll_valid = 1'b1;
        expect_state(1'b1, 5'b10100, 6, "R7 reset pll bad, frozen");
        write_reg(3'b100);
        expect_state(1'b0, 5'b00000, 7, "R7 sticky clear exit");
        // R7 hard reset with PLL valid -> main, then PLL drop after release
        @(negedge clk); hard_rst = 1'b1;
        repeat (10) @(negedge clk);
        hard_rst = 1'b0;
        @(negedge clk); pll_valid = 1'b0;
        repeat (5) @(negedge clk); pll_valid = 1'b1;
        expect_state(1'b0, 5'b00000, 7, "R7 reset pll good, frozen");
        // R7 PLL fails mid-reset -> backup
        @(negedge clk); hard_rst = 1'b1;
        repeat (4) @(negedge clk); pll_valid = 1'b0;
        repeat (3) @(negedge clk); pll_valid = 1'b1;
        repeat (3) @(negedge clk); hard_rst = 1'b0;
        expect_state(1'b1, 5'b10100, 7, "R7 pll lost during reset");
        write_reg(3'b100);
        expect_state(1'b0, 5'b00000, 8, "R7 exit after mid-reset fail");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule